// File: doc/BRIEF.md
# Census Disparity Selector with Rank-Based Minimum

This block turns a stream of census codes from a rectified stereo pair into one disparity per pixel. Each cycle it may accept one left-image code and the right-image code at the same column. A history of recent right codes forms the candidate window. Candidate `d` is the right code seen `d` accepted pixels earlier. The cost of a candidate is the Hamming distance between the left code and that candidate, found with an XOR and a bit count.

The best candidate is found without a comparator tree. Every pair of costs is compared once. For every candidate the block counts how many others beat it. The candidate that nobody beats has rank zero, and its index is the disparity. Ties between equal costs go to the lower index. The work is split into three register stages (cost, rank, decision), so the block produces one result per clock. At the start of a line the window is not yet full. For those pixels the block reports disparity zero and raises a flag.

Top module: `census_disp_select`

## Requirements
- R1: Candidate `d` (0 ≤ d < NUM_CAND, default 40) is the right code presented with the `d`-th most recent accepted pixel. `d = 0` is the right code presented together with the left code. A cycle with `in_valid` low shifts nothing and produces no result.
- R2: The cost of a candidate is the number of 1 bits in `in_left XOR candidate`. For a pixel that is not partial, `out_cost` reports the cost of the chosen candidate.
- R3: For a pixel that is not partial, `out_disp` is the index of a candidate whose cost is the smallest in the window. `out_cost` equals that smallest cost.
- R4: When several candidates share the smallest cost, `out_disp` is the lowest of their indices.
- R5: The pixel presented with `in_line_start` high is at position 0 of its line. Positions count accepted pixels. Pixels at positions 0 to NUM_CAND-2 (0 to 38 by default) give `out_partial` = 1, `out_disp` = 0 and `out_cost` = 0. Later pixels give `out_partial` = 0.
- R6: A pixel accepted at a rising edge produces `out_valid` high during the cycle after the third rising edge counted from the accepting one. The block accepts one pixel per clock with no gaps. `out_valid` is high only for accepted pixels.
- R7: Synchronous active-high `rst` clears `out_valid` and drops all results in flight. The first pixel accepted after reset is at position 0, even without `in_line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A pixel is presented this cycle |
| in_line_start | input | 1 | The presented pixel is the first of a line |
| in_left | input | CODE_W | Left-image census code |
| in_right | input | CODE_W | Right-image census code at the same column |
| out_valid | output | 1 | Result present |
| out_disp | output | $clog2(NUM_CAND) | Chosen disparity |
| out_partial | output | 1 | Window was not full; disparity forced to zero |
| out_cost | output | $clog2(CODE_W+1) | Hamming cost of the chosen candidate |

## Verification
A candidate history that shifts at the wrong time, or one that misses a slot, shows up as a wrong disparity. The directed single-match pixels catch it within one result, because their correct answer is a unique zero-cost candidate at a known depth. A wrong tie order in the rank matrix shows up in the cost-tie pixels, where the reported index would be higher than the lowest tied one. A position counter that saturates or restarts wrongly flips `out_partial` at a line edge, which is visible three cycles after the pixel that caused it. Rank values that do not form a permutation would give no candidate or two candidates at rank zero. Internal checks report this in the cycle it happens, before the result reaches the ports.

// File: rtl/census_disp_pkg.sv
package census_disp_pkg;

    localparam int unsigned DEF_CANDS  = 40;
    localparam int unsigned DEF_CODE_W = 8;

    // Control bits that travel alongside each pixel through the stages.
    typedef struct packed {
        logic valid;
        logic partial;
    } pix_ctl_t;

    function automatic int unsigned bits_for(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/census_cand_window.sv
module census_cand_window
    import census_disp_pkg::*;
#(
    parameter int unsigned NUM_CAND = DEF_CANDS,
    parameter int unsigned CODE_W   = DEF_CODE_W,
    localparam int unsigned DIST_W  = bits_for(CODE_W + 1),
    localparam int unsigned POS_W   = bits_for(NUM_CAND)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic                             in_line_start,
    input  logic [CODE_W-1:0]                in_left,
    input  logic [CODE_W-1:0]                in_right,
    output pix_ctl_t                         s1_ctl,
    output logic [NUM_CAND-1:0][DIST_W-1:0]  s1_dist
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(NUM_CAND - 1);

    logic [NUM_CAND-2:0][CODE_W-1:0] hist_q;
    logic [NUM_CAND-1:0][CODE_W-1:0] cand;
    logic [NUM_CAND-1:0][DIST_W-1:0] dist_c;
    logic [POS_W-1:0]                pos_q;
    logic [POS_W-1:0]                pos_now;
    logic                            partial_c;

    // Right-code history: slot k holds the code k+1 accepted pixels back.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (in_valid) begin
            hist_q[0] <= in_right;
            for (int k = 1; k < int'(NUM_CAND) - 1; k++) begin
                hist_q[k] <= hist_q[k-1];
            end
        end
    end

    always_comb begin
        cand[0] = in_right;
        for (int d = 1; d < int'(NUM_CAND); d++) begin
            cand[d] = hist_q[d-1];
        end
    end

    // Hamming cost per candidate.
    always_comb begin
        logic [CODE_W-1:0] diff;
        int                ones;
        for (int d = 0; d < int'(NUM_CAND); d++) begin
            diff = in_left ^ cand[d];
            ones = 0;
            for (int b = 0; b < int'(CODE_W); b++) begin
                ones = ones + int'(diff[b]);
            end
            dist_c[d] = DIST_W'(ones);
        end
    end

    // Position inside the line, saturating once the window is full.
    assign pos_now   = in_line_start ? '0 : pos_q;
    assign partial_c = (pos_now != POS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (in_valid) begin
            pos_q <= (pos_now == POS_LAST) ? pos_now : pos_now + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl  <= '0;
            s1_dist <= '0;
        end else begin
            s1_ctl.valid   <= in_valid;
            s1_ctl.partial <= partial_c;
            s1_dist        <= dist_c;
        end
    end

    // R5
    pos_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q <= POS_LAST);

    // R1
    idle_keeps_history_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(hist_q) && $stable(pos_q));

endmodule

// File: rtl/census_rank_stage.sv
module census_rank_stage
    import census_disp_pkg::*;
#(
    parameter int unsigned NUM_CAND = DEF_CANDS,
    parameter int unsigned DIST_W   = bits_for(DEF_CODE_W + 1),
    localparam int unsigned RANK_W  = bits_for(NUM_CAND)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  pix_ctl_t                         s1_ctl,
    input  logic [NUM_CAND-1:0][DIST_W-1:0]  s1_dist,
    output pix_ctl_t                         s2_ctl,
    output logic [NUM_CAND-1:0][DIST_W-1:0]  s2_dist,
    output logic [NUM_CAND-1:0][RANK_W-1:0]  s2_rank
);

    // beaten[i][j] = 1 when candidate j ranks ahead of candidate i.
    logic [NUM_CAND-1:0][NUM_CAND-1:0] beaten;
    logic [NUM_CAND-1:0][RANK_W-1:0]   rank_c;

    // One comparator per unordered pair; equal costs favour the lower index.
    always_comb begin
        logic hi_worse;
        beaten = '0;
        for (int i = 0; i < int'(NUM_CAND); i++) begin
            for (int j = i + 1; j < int'(NUM_CAND); j++) begin
                hi_worse     = (s1_dist[i] > s1_dist[j]);
                beaten[i][j] = hi_worse;
                beaten[j][i] = !hi_worse;
            end
        end
    end

    always_comb begin
        int cnt;
        for (int i = 0; i < int'(NUM_CAND); i++) begin
            cnt = 0;
            for (int j = 0; j < int'(NUM_CAND); j++) begin
                cnt = cnt + int'(beaten[i][j]);
            end
            rank_c[i] = RANK_W'(cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_ctl  <= '0;
            s2_dist <= '0;
            s2_rank <= '0;
        end else begin
            s2_ctl  <= s1_ctl;
            s2_dist <= s1_dist;
            s2_rank <= rank_c;
        end
    end

endmodule

// File: rtl/census_rank_decide.sv
module census_rank_decide
    import census_disp_pkg::*;
#(
    parameter int unsigned NUM_CAND = DEF_CANDS,
    parameter int unsigned DIST_W   = bits_for(DEF_CODE_W + 1),
    localparam int unsigned RANK_W  = bits_for(NUM_CAND),
    localparam int unsigned DISP_W  = bits_for(NUM_CAND)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  pix_ctl_t                         s2_ctl,
    input  logic [NUM_CAND-1:0][DIST_W-1:0]  s2_dist,
    input  logic [NUM_CAND-1:0][RANK_W-1:0]  s2_rank,
    output logic                             out_valid,
    output logic [DISP_W-1:0]                out_disp,
    output logic                             out_partial,
    output logic [DIST_W-1:0]                out_cost
);

    logic [NUM_CAND-1:0] at_front;
    logic [DISP_W-1:0]   win_idx;
    logic [DIST_W-1:0]   win_cost;
    logic                min_holds;
    logic                tie_holds;

    always_comb begin
        for (int i = 0; i < int'(NUM_CAND); i++) begin
            at_front[i] = (s2_rank[i] == '0);
        end
    end

    // Encoder over the rank-zero flags.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < int'(NUM_CAND); i++) begin
            if (at_front[i]) begin
                win_idx = win_idx | DISP_W'(i);
            end
        end
        win_cost = s2_dist[win_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_disp    <= '0;
            out_partial <= 1'b0;
            out_cost    <= '0;
        end else begin
            out_valid   <= s2_ctl.valid;
            out_partial <= s2_ctl.partial;
            out_disp    <= s2_ctl.partial ? '0 : win_idx;
            out_cost    <= s2_ctl.partial ? '0 : win_cost;
        end
    end

    // Independent scan of the costs, used only by the checks below.
    always_comb begin
        min_holds = 1'b1;
        tie_holds = 1'b1;
        for (int j = 0; j < int'(NUM_CAND); j++) begin
            if (s2_dist[j] < win_cost) begin
                min_holds = 1'b0;
            end
            if ((j < int'(win_idx)) && (s2_dist[j] == win_cost)) begin
                tie_holds = 1'b0;
            end
        end
    end

    // R3
    single_front_chk: assert property (@(posedge clk) disable iff (rst)
        s2_ctl.valid |-> $countones(at_front) == 1);

    // R3
    front_is_minimum_chk: assert property (@(posedge clk) disable iff (rst)
        s2_ctl.valid |-> min_holds);

    // R4
    tie_lowest_index_chk: assert property (@(posedge clk) disable iff (rst)
        s2_ctl.valid |-> tie_holds);

    // R5
    partial_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_partial |-> out_disp == '0 && out_cost == '0);

    // R3
    disp_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> int'(out_disp) < int'(NUM_CAND));

endmodule

// File: rtl/census_disp_select.sv
module census_disp_select
    import census_disp_pkg::*;
#(
    parameter int unsigned NUM_CAND = DEF_CANDS,
    parameter int unsigned CODE_W   = DEF_CODE_W,
    localparam int unsigned DIST_W  = bits_for(CODE_W + 1),
    localparam int unsigned RANK_W  = bits_for(NUM_CAND),
    localparam int unsigned DISP_W  = bits_for(NUM_CAND)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_line_start,
    input  logic [CODE_W-1:0] in_left,
    input  logic [CODE_W-1:0] in_right,
    output logic              out_valid,
    output logic [DISP_W-1:0] out_disp,
    output logic              out_partial,
    output logic [DIST_W-1:0] out_cost
);

    pix_ctl_t                        s1_ctl;
    pix_ctl_t                        s2_ctl;
    logic [NUM_CAND-1:0][DIST_W-1:0] s1_dist;
    logic [NUM_CAND-1:0][DIST_W-1:0] s2_dist;
    logic [NUM_CAND-1:0][RANK_W-1:0] s2_rank;

    census_cand_window #(
        .NUM_CAND (NUM_CAND),
        .CODE_W   (CODE_W)
    ) u_window (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_line_start (in_line_start),
        .in_left       (in_left),
        .in_right      (in_right),
        .s1_ctl        (s1_ctl),
        .s1_dist       (s1_dist)
    );

    census_rank_stage #(
        .NUM_CAND (NUM_CAND),
        .DIST_W   (DIST_W)
    ) u_rank (
        .clk     (clk),
        .rst     (rst),
        .s1_ctl  (s1_ctl),
        .s1_dist (s1_dist),
        .s2_ctl  (s2_ctl),
        .s2_dist (s2_dist),
        .s2_rank (s2_rank)
    );

    census_rank_decide #(
        .NUM_CAND (NUM_CAND),
        .DIST_W   (DIST_W)
    ) u_decide (
        .clk         (clk),
        .rst         (rst),
        .s2_ctl      (s2_ctl),
        .s2_dist     (s2_dist),
        .s2_rank     (s2_rank),
        .out_valid   (out_valid),
        .out_disp    (out_disp),
        .out_partial (out_partial),
        .out_cost    (out_cost)
    );

endmodule

// File: tb/test_census_disp_select.sv
module test_census_disp_select;

    localparam int CLK_PERIOD = 10;
    localparam int NC  = 40;
    localparam int CW  = 8;
    localparam int DW  = 6;
    localparam int CSW = 4;

    typedef struct {
        int            stamp;
        logic [DW-1:0] disp;
        logic          part;
        logic [CSW-1:0] cost;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_line_start;
    logic [CW-1:0] in_left;
    logic [CW-1:0] in_right;
    logic          out_valid;
    logic [DW-1:0] out_disp;
    logic          out_partial;
    logic [CSW-1:0] out_cost;

    int   n_cmp  = 0;
    int   n_bad  = 0;
    int   n_step = 0;
    int   m_pos  = 0;
    logic [CW-1:0] m_hist [NC-1];
    exp_t q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    census_disp_select i_census_disp_select (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_line_start (in_line_start),
        .in_left       (in_left),
        .in_right      (in_right),
        .out_valid     (out_valid),
        .out_disp      (out_disp),
        .out_partial   (out_partial),
        .out_cost      (out_cost)
    );

    function automatic int popc(input logic [CW-1:0] v);
        int c = 0;
        for (int b = 0; b < CW; b++) c += int'(v[b]);
        return c;
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (step %0d)", req, what, act, exp, n_step);
        end
    endtask

    task automatic check_out();
        if (q.size() > 0 && q[0].stamp == n_step - 3) begin
            exp_t e = q.pop_front();
            cmp("R6", "out_valid", int'(out_valid), 1);
            cmp("R5", "out_partial", int'(out_partial), int'(e.part));
            cmp(e.tag, "out_disp", int'(out_disp), int'(e.disp));
            cmp("R2", "out_cost", int'(out_cost), int'(e.cost));
        end else begin
            cmp("R6", "out_valid idle", int'(out_valid), 0);
        end
    endtask

    // Reference model: strict less-than scan keeps the lowest index on ties.
    task automatic model(input logic ls, input logic [CW-1:0] l, input logic [CW-1:0] r,
                         input string tag);
        exp_t e;
        int best;
        int bidx;
        int c;
        logic [CW-1:0] cd;
        if (ls) m_pos = 0;
        e.stamp = n_step;
        e.tag   = tag;
        if (m_pos < NC - 1) begin
            e.part = 1'b1;
            e.disp = '0;
            e.cost = '0;
        end else begin
            best = CW + 1;
            bidx = 0;
            for (int d = 0; d < NC; d++) begin
                cd = (d == 0) ? r : m_hist[d-1];
                c = popc(l ^ cd);
                if (c < best) begin
                    best = c;
                    bidx = d;
                end
            end
            e.part = 1'b0;
            e.disp = DW'(bidx);
            e.cost = CSW'(best);
        end
        q.push_back(e);
        for (int k = NC - 2; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = r;
        if (m_pos < NC - 1) m_pos++;
    endtask

    task automatic step(input logic v, input logic ls, input logic [CW-1:0] l,
                        input logic [CW-1:0] r, input string tag);
        @(negedge clk);
        n_step++;
        check_out();
        in_valid      = v;
        in_line_start = ls;
        in_left       = l;
        in_right      = r;
        if (v) model(ls, l, r, tag);
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        n_step++;
        check_out();
        rst      = 1'b1;
        in_valid = 1'b0;
        q.delete();
        m_pos = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            n_step++;
            // R7: no result while or just after reset is applied
            cmp("R7", "out_valid in reset", int'(out_valid), 0);
        end
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stimulus
        void'($urandom(32'd2024));
        for (int k = 0; k < NC - 1; k++) m_hist[k] = '0;
        rst = 1'b1;
        in_valid = 1'b0;
        in_line_start = 1'b0;
        in_left = '0;
        in_right = '0;
        repeat (3) @(negedge clk);
        // R7: reset state
        cmp("R7", "out_valid after reset", int'(out_valid), 0);
        rst = 1'b0;

        // R5, R4: all-equal line, every full pixel ties at index 0
        for (int p = 0; p < 45; p++)
            step(1'b1, p == 0, 8'h5A, 8'h5A, "R4");

        // R1: unique zero-cost match at the deepest slot
        for (int p = 0; p < 42; p++)
            step(1'b1, p == 0, (p == 39) ? 8'h00 : 8'h0F,
                 (p == 0) ? 8'h00 : 8'hFF, "R1");

        // R4: zero-cost ties at depths 5 and 20, lower index must win
        for (int p = 0; p < 41; p++)
            step(1'b1, p == 0, (p == 39) ? 8'h00 : 8'hF0,
                 (p == 34 || p == 19) ? 8'h00 : 8'hFF, "R4");

        // R1, R6: bubbles inside a line must not shift the window
        for (int p = 0; p < 60; p++) begin
            step(1'b1, p == 0, 8'($urandom), 8'($urandom), "R1");
            if (p % 7 == 3) step(1'b0, 1'b0, 8'hFF, 8'h00, "R1");
        end

        // R3: constrained random lines, near-matching codes and bubbles
        for (int ln = 0; ln < 5; ln++) begin
            for (int p = 0; p < 70; p++) begin
                logic [CW-1:0] l = 8'($urandom);
                logic [CW-1:0] r = (($urandom % 3) == 0) ? l ^ 8'(1 << ($urandom % 8))
                                                          : 8'($urandom);
                step(($urandom % 5) != 0, p == 0, l, r, "R3");
            end
        end

        // R7: reset mid-line; following pixels restart at position 0
        for (int p = 0; p < 45; p++)
            step(1'b1, p == 0, 8'($urandom), 8'($urandom), "R3");
        do_reset(2);
        for (int p = 0; p < 44; p++)
            step(1'b1, 1'b0, 8'($urandom), 8'($urandom), "R7");

        // R5: new line start mid-stream restarts the partial span
        for (int p = 0; p < 10; p++)
            step(1'b1, p == 0, 8'($urandom), 8'($urandom), "R5");

        for (int k = 0; k < 6; k++) step(1'b0, 1'b0, '0, '0, "R6");
        cmp("R6", "results left pending", q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule